// File: doc/BRIEF.md
# On-the-fly AES-128 round key generator

This block produces the eleven AES-128 round keys from a 128-bit cipher key as they are needed. No expanded schedule is stored. Only the current round key and the current round constant are held. A cipher data path sits next to it and pulls one key per request strobe.

In encrypt order, the keys come out from index 0 up to index 10. In decrypt order, the block first runs a forward expansion pass internally until it holds the last round key. It then runs the expansion backwards and hands out the keys from index 10 down to 0. One step circuit does both walks. It has a single four-byte S-box word, a single rotate, and a round constant that is either multiplied or divided by x in GF(2^8) on each step.

After the last key of a sequence has been taken, the block goes idle until the next start.

Top module: `aes128_keysched_otf`

## Requirements
- R1: While reset is held and just after it, key_valid_o and busy_o are 0 and round_idx_o is 0.
- R2: A start with decrypt_i=0 makes key_valid_o=1 on the next cycle, with round_idx_o=0 and round_key_o equal to the cipher key.
- R3: In encrypt order, each next_i pulse taken while key_valid_o=1 and round_idx_o<10 raises round_idx_o by one. round_key_o becomes the next standard AES-128 expansion key. In that step, the low word is rotated left by a byte, each byte goes through the S-box, and the high byte is XORed with the round constant. The constant starts at 0x01 and is multiplied by x modulo 0x11B on each step.
- R4: For cipher key 2b7e151628aed2a6abf7158809cf4f3c, round key 10 is d014f9a8c9ee2589e13f0cc8b6630ca6.
- R5: A start with decrypt_i=1 holds busy_o=1 and key_valid_o=0 for exactly 10 cycles. On the next cycle, key_valid_o=1 with round_idx_o=10 and round_key_o equal to round key 10.
- R6: next_i has no effect while busy_o=1. Neither the busy length nor the first decrypt key changes.
- R7: In decrypt order, each next_i pulse taken while round_idx_o>0 lowers round_idx_o by one and yields the preceding expansion key. The key shown at index 0 equals the cipher key.
- R8: A next_i pulse at the final key of a sequence (index 10 when encrypting, index 0 when decrypting) drops key_valid_o to 0 and leaves busy_o at 0.
- R9: next_i while idle leaves key_valid_o at 0.
- R10: start_i restarts the block at any time, including during the busy pass and in the middle of a sequence. The new mode and key take effect.
- R11: Without next_i or start_i, round_key_o and round_idx_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load cipher key and begin a sequence |
| decrypt_i | input | 1 | Sequence order at start: 0 ascending, 1 descending |
| cipher_key_i | input | 128 | Cipher key, byte 0 in bits 127:120 |
| next_i | input | 1 | Request the following round key |
| round_key_o | output | 128 | Current round key |
| round_idx_o | output | 4 | Index of round_key_o |
| key_valid_o | output | 1 | round_key_o is ready for use |
| busy_o | output | 1 | Forward pass before a decrypt sequence is running |

## Verification
The hardest situation to reach is a restart that lands during the internal forward pass or in the middle of a backward walk. The round constant register then holds a value far from its start value, and a stale constant would go unnoticed by a test that only runs complete sequences. The stimulus includes directed restarts at several points of both walks. Random keys and random orders follow, with random idle gaps between requests. Every key the block shows is compared with an expansion the bench computes by its own method.

// File: rtl/aes_ks_pkg.sv
package aes_ks_pkg;
  localparam int KEY_W      = 128;
  localparam int WORD_W     = 32;
  localparam int NUM_ROUNDS = 10;
  localparam int IDX_W      = $clog2(NUM_ROUNDS + 1);
  localparam logic [7:0] GF_POLY  = 8'h1B;
  localparam logic [7:0] GF_IPOLY = 8'h8D;
  // constant "before" round 1, so that one multiply by x gives 0x01
  localparam logic [7:0] RC_SEED  = 8'h8D;
  localparam logic [7:0] AFF_C    = 8'h63;

  typedef enum logic [1:0] {KS_IDLE, KS_PRE, KS_EMIT} ks_state_e;

  function automatic logic [7:0] gf_mul_x(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? GF_POLY : 8'h00);
  endfunction

  function automatic logic [7:0] gf_div_x(input logic [7:0] a);
    return {1'b0, a[7:1]} ^ (a[0] ? GF_IPOLY : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] p;
    acc = '0;
    p   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ p;
      p = gf_mul_x(p);
    end
    return acc;
  endfunction

  // a^254 is the multiplicative inverse (and maps 0 to 0)
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r;
    logic [7:0] p;
    logic [7:0] e;
    r = 8'h01;
    p = a;
    e = 8'd254;
    for (int i = 0; i < 8; i++) begin
      if (e[i]) r = gf_mul(r, p);
      p = gf_mul(p, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] sbox_byte(input logic [7:0] a);
    logic [7:0] v;
    logic [7:0] s;
    v = gf_inv(a);
    for (int i = 0; i < 8; i++)
      s[i] = v[i] ^ v[(i+4)%8] ^ v[(i+5)%8] ^ v[(i+6)%8] ^ v[(i+7)%8] ^ AFF_C[i];
    return s;
  endfunction

  function automatic logic [WORD_W-1:0] rot_word(input logic [WORD_W-1:0] w);
    return {w[WORD_W-9:0], w[WORD_W-1 -: 8]};
  endfunction
endpackage

// File: rtl/ks_subword.sv
module ks_subword
  import aes_ks_pkg::*;
#(
  parameter int BYTES = WORD_W / 8
) (
  input  logic [BYTES*8-1:0] word_i,
  output logic [BYTES*8-1:0] word_o
);
  for (genvar b = 0; b < BYTES; b++) begin : g_sbox
    assign word_o[b*8 +: 8] = sbox_byte(word_i[b*8 +: 8]);
  end
endmodule

// File: rtl/ks_round_step.sv
module ks_round_step
  import aes_ks_pkg::*;
(
  input  logic [KEY_W-1:0]  key_i,
  input  logic [7:0]        rc_i,
  input  logic              reverse_i,
  output logic [KEY_W-1:0]  key_o,
  output logic [7:0]        rc_o,
  output logic [WORD_W-1:0] sub_src_o
);
  localparam int NW = KEY_W / WORD_W;

  logic [WORD_W-1:0] cw [NW];
  logic [WORD_W-1:0] fw [NW];
  logic [WORD_W-1:0] rw [NW];
  logic [WORD_W-1:0] sub_out;
  logic [WORD_W-1:0] mix;
  logic [7:0]        rc_fwd;
  logic [7:0]        rc_use;

  for (genvar i = 0; i < NW; i++) begin : g_split
    assign cw[i] = key_i[KEY_W-1-i*WORD_W -: WORD_W];
  end

  assign rc_fwd = gf_mul_x(rc_i);
  assign rc_use = reverse_i ? rc_i : rc_fwd;

  // reverse: recover previous words 1..3 by XOR of neighbours
  for (genvar i = 1; i < NW; i++) begin : g_rev
    assign rw[i] = cw[i] ^ cw[i-1];
  end

  // single shared S-box word: forward takes current last word, reverse the recovered one
  assign sub_src_o = reverse_i ? rw[NW-1] : cw[NW-1];

  ks_subword u_sub (
    .word_i (rot_word(sub_src_o)),
    .word_o (sub_out)
  );

  assign mix   = sub_out ^ {rc_use, {(WORD_W-8){1'b0}}};
  assign rw[0] = cw[0] ^ mix;

  assign fw[0] = cw[0] ^ mix;
  for (genvar i = 1; i < NW; i++) begin : g_fwd
    assign fw[i] = cw[i] ^ fw[i-1];
  end

  for (genvar i = 0; i < NW; i++) begin : g_join
    assign key_o[KEY_W-1-i*WORD_W -: WORD_W] = reverse_i ? rw[i] : fw[i];
  end

  assign rc_o = reverse_i ? gf_div_x(rc_i) : rc_fwd;
endmodule

// File: rtl/ks_ctrl.sv
module ks_ctrl
  import aes_ks_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             decrypt_i,
  input  logic             next_i,
  output logic             load_o,
  output logic             step_o,
  output logic             step_rev_o,
  output logic             finish_o,
  output logic             dec_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             valid_o,
  output logic             busy_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ROUNDS);

  ks_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic             dec_q;
  logic             at_end;
  logic             pre_step;
  logic             adv;

  assign at_end   = dec_q ? (idx_q == '0) : (idx_q == LAST_IDX);
  assign pre_step = (state_q == KS_PRE) && !start_i;
  assign adv      = (state_q == KS_EMIT) && next_i && !start_i && !at_end;
  assign finish_o = (state_q == KS_EMIT) && next_i && !start_i && at_end;

  assign load_o     = start_i;
  assign step_o     = pre_step || adv;
  assign step_rev_o = adv && dec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= KS_IDLE;
      idx_q   <= '0;
      dec_q   <= 1'b0;
    end else if (start_i) begin
      state_q <= decrypt_i ? KS_PRE : KS_EMIT;
      idx_q   <= '0;
      dec_q   <= decrypt_i;
    end else if (pre_step) begin
      idx_q <= idx_q + 1'b1;
      if (idx_q == LAST_IDX - 1'b1) state_q <= KS_EMIT;
    end else if (adv) begin
      idx_q <= dec_q ? idx_q - 1'b1 : idx_q + 1'b1;
    end else if (finish_o) begin
      state_q <= KS_IDLE;
      idx_q   <= '0;
    end
  end

  assign dec_o   = dec_q;
  assign idx_o   = idx_q;
  assign valid_o = (state_q == KS_EMIT);
  assign busy_o  = (state_q == KS_PRE);
endmodule

// File: rtl/aes128_keysched_otf.sv
module aes128_keysched_otf
  import aes_ks_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             decrypt_i,
  input  logic [127:0]     cipher_key_i,
  input  logic             next_i,
  output logic [127:0]     round_key_o,
  output logic [3:0]       round_idx_o,
  output logic             key_valid_o,
  output logic             busy_o
);
  logic [KEY_W-1:0]  key_q;
  logic [7:0]        rc_q;
  logic [KEY_W-1:0]  key_nxt;
  logic [7:0]        rc_nxt;
  logic [WORD_W-1:0] sub_src;
  logic              load_evt;
  logic              step_evt;
  logic              step_rev;
  logic              finish_evt;
  logic              ctrl_dec;
  logic [IDX_W-1:0]  idx;

  ks_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .decrypt_i  (decrypt_i),
    .next_i     (next_i),
    .load_o     (load_evt),
    .step_o     (step_evt),
    .step_rev_o (step_rev),
    .finish_o   (finish_evt),
    .dec_o      (ctrl_dec),
    .idx_o      (idx),
    .valid_o    (key_valid_o),
    .busy_o     (busy_o)
  );

  ks_round_step u_step (
    .key_i     (key_q),
    .rc_i      (rc_q),
    .reverse_i (step_rev),
    .key_o     (key_nxt),
    .rc_o      (rc_nxt),
    .sub_src_o (sub_src)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0;
      rc_q  <= RC_SEED;
    end else if (load_evt) begin
      key_q <= cipher_key_i;
      rc_q  <= RC_SEED;
    end else if (step_evt) begin
      key_q <= key_nxt;
      rc_q  <= rc_nxt;
    end
  end

  assign round_key_o = key_q;
  assign round_idx_o = 4'(idx);
endmodule

// File: rtl/ks_checker.sv
module ks_checker (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         decrypt_i,
  input logic [127:0] cipher_key_i,
  input logic         next_i,
  input logic [127:0] round_key_o,
  input logic [3:0]   round_idx_o,
  input logic         key_valid_o,
  input logic         busy_o,
  input logic         ctrl_dec
);
  logic [4:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        busy_cnt <= '0;
    else if (start_i)  busy_cnt <= '0;
    else if (busy_o)   busy_cnt <= busy_cnt + 1'b1;
  end

  // R2
  a_r2_enc_load: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !decrypt_i |=> key_valid_o && round_idx_o == 4'd0 && round_key_o == $past(cipher_key_i));

  // R3
  a_r3_fwd_inc: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid_o && !ctrl_dec && next_i && !start_i && round_idx_o != 4'd10
    |=> round_idx_o == $past(round_idx_o) + 4'd1);

  // R5
  a_r5_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !key_valid_o);

  // R5
  a_r5_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) && !$past(start_i) |-> busy_cnt == 5'd10 && key_valid_o && round_idx_o == 4'd10);

  // R7
  a_r7_rev_dec: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid_o && ctrl_dec && next_i && !start_i && round_idx_o != 4'd0
    |=> round_idx_o == $past(round_idx_o) - 4'd1);

  // R8
  a_r8_end: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid_o && next_i && !start_i && round_idx_o == (ctrl_dec ? 4'd0 : 4'd10)
    |=> !key_valid_o && !busy_o);

  // R11
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid_o && !next_i && !start_i |=> $stable(round_key_o) && $stable(round_idx_o));
endmodule

bind aes128_keysched_otf ks_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .decrypt_i    (decrypt_i),
  .cipher_key_i (cipher_key_i),
  .next_i       (next_i),
  .round_key_o  (round_key_o),
  .round_idx_o  (round_idx_o),
  .key_valid_o  (key_valid_o),
  .busy_o       (busy_o),
  .ctrl_dec     (ctrl_dec)
);

// File: tb/aes128_keysched_otf_tb.sv
module aes128_keysched_otf_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic         decrypt_i = 1'b0;
  logic [127:0] cipher_key_i = '0;
  logic         next_i = 1'b0;
  logic [127:0] round_key_o;
  logic [3:0]   round_idx_o;
  logic         key_valid_o;
  logic         busy_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0]   tb_sbox [256];
  logic [127:0] exp_k [11];

  localparam logic [127:0] STD_KEY = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] STD_K10 = 128'hd014f9a8c9ee2589e13f0cc8b6630ca6;

  always #10 clk = ~clk;

  aes128_keysched_otf u_dut (.*);

  function automatic logic [7:0] tb_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h11B << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  task automatic build_sbox();
    for (int a = 0; a < 256; a++) begin
      logic [7:0] inv = 8'h00;
      for (int b = 1; b < 256; b++) if (tb_mul(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
      tb_sbox[a] = inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3) ^ rotl8(inv, 4) ^ 8'h63;
    end
  endtask

  task automatic expand(input logic [127:0] k);
    logic [31:0] w [44];
    logic [7:0]  rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      logic [31:0] t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {tb_sbox[t[31:24]] ^ rc, tb_sbox[t[23:16]], tb_sbox[t[15:8]], tb_sbox[t[7:0]]};
        rc = tb_mul(rc, 8'h02);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) exp_k[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic do_start(input bit dec, input logic [127:0] k);
    start_i = 1'b1; decrypt_i = dec; cipher_key_i = k;
    cyc();
    start_i = 1'b0;
  endtask

  task automatic do_next();
    next_i = 1'b1;
    cyc();
    next_i = 1'b0;
  endtask

  task automatic check_key(input string req, input int r);
    check(key_valid_o && round_idx_o == 4'(r), {req, " idx/valid"},
          {123'd0, key_valid_o, round_idx_o}, {123'd0, 1'b1, 4'(r)});
    check(round_key_o == exp_k[r], {req, " key"}, round_key_o, exp_k[r]);
  endtask

  // waits out the busy pass, optionally pressing next_i (R6); returns the cycle count
  task automatic wait_busy(input bit press, output int cnt);
    cnt = 0;
    next_i = press;
    while (busy_o && cnt < 40) begin
      check(!key_valid_o, "R5 valid low while busy", {127'd0, key_valid_o}, 128'd0);
      cnt++;
      cyc();
    end
    next_i = 1'b0;
  endtask

  task automatic walk(input bit dec, input int gaps);
    for (int s = 0; s < 11; s++) begin
      int r = dec ? 10 - s : s;
      check_key(dec ? "R7" : "R3", r);
      for (int g = 0; g < gaps; g++) cyc();
      if (gaps > 0) check_key("R11 hold", r);
      do_next();
    end
    check(!key_valid_o && !busy_o, "R8 end of sequence", {126'd0, key_valid_o, busy_o}, 128'd0);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int cnt;
    void'($urandom(32'd2024));
    build_sbox();
    cyc(); cyc();
    check(!key_valid_o && !busy_o && round_idx_o == 0, "R1 reset state",
          {122'd0, key_valid_o, busy_o, round_idx_o}, 128'd0);
    rst_n = 1'b1;
    cyc();
    check(!key_valid_o && !busy_o && round_idx_o == 0, "R1 after reset",
          {122'd0, key_valid_o, busy_o, round_idx_o}, 128'd0);

    // R9: next while idle
    do_next();
    check(!key_valid_o, "R9 next while idle", {127'd0, key_valid_o}, 128'd0);

    // R2/R3/R4/R8 with the standard key
    expand(STD_KEY);
    do_start(1'b0, STD_KEY);
    check(round_key_o == STD_KEY, "R2 key0 is cipher key", round_key_o, STD_KEY);
    for (int r = 0; r < 10; r++) begin
      check_key("R3", r);
      do_next();
    end
    check(round_key_o == STD_K10, "R4 round key 10", round_key_o, STD_K10);
    do_next();
    check(!key_valid_o && !busy_o, "R8 end of encrypt", {126'd0, key_valid_o, busy_o}, 128'd0);
    do_next();
    check(!key_valid_o, "R9 next after end", {127'd0, key_valid_o}, 128'd0);

    // R5/R6/R7 decrypt with the standard key, next pressed during busy
    do_start(1'b1, STD_KEY);
    wait_busy(1'b1, cnt);
    check(cnt == 10, "R5/R6 busy length", 128'(cnt), 128'd10);
    check(round_key_o == STD_K10, "R5 first decrypt key", round_key_o, STD_K10);
    walk(1'b1, 0);

    // R10: restart during busy, then mid-sequence in both orders
    do_start(1'b1, 128'h0);
    cyc(); cyc(); cyc(); cyc();
    expand(128'hffffffffffffffffffffffffffffffff);
    do_start(1'b0, 128'hffffffffffffffffffffffffffffffff);
    check_key("R10 enc after busy restart", 0);
    do_next(); do_next(); do_next(); do_next(); do_next();
    check_key("R10 enc mid", 5);
    expand(128'h000102030405060708090a0b0c0d0e0f);
    do_start(1'b1, 128'h000102030405060708090a0b0c0d0e0f);
    wait_busy(1'b0, cnt);
    check(cnt == 10, "R10 busy after mid restart", 128'(cnt), 128'd10);
    check_key("R10 dec start", 10);
    do_next(); do_next(); do_next(); do_next();
    check_key("R7 dec mid", 6);
    do_start(1'b1, 128'h000102030405060708090a0b0c0d0e0f);
    wait_busy(1'b0, cnt);
    check(cnt == 10, "R10 dec restart mid walk", 128'(cnt), 128'd10);
    walk(1'b1, 1);

    // random keys, orders and idle gaps
    for (int t = 0; t < 24; t++) begin
      logic [127:0] k = {$urandom, $urandom, $urandom, $urandom};
      bit dec = 1'($urandom % 2);
      expand(k);
      do_start(dec, k);
      if (dec) begin
        wait_busy(1'($urandom % 2), cnt);
        check(cnt == 10, "R5 random busy length", 128'(cnt), 128'd10);
      end
      walk(dec, int'($urandom % 3));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule